// File: doc/BRIEF.md
# Index-Data Configuration Port with Unlock Sequence

This block gives a host bus access to a small configuration space through only two byte-wide locations. One location, the index port, holds the number of the register to reach. The other, the data port, reads or writes that register. The whole space stays sealed until a key byte is written to the index port twice in a row. A separate lock byte seals it again.

Once the space is open, a select register picks one of several logical devices. Each device has its own bank of registers: an enable flag, a 16-bit base address held as two bytes, and an interrupt number. These values drive the block's outputs and configure the devices around it. A few global registers can be reached whichever device is selected: two read-only identity bytes and an output pin select byte.

Top module: `cfgp_port`

## Requirements
- R1: After reset the port is locked (`cfg_open` low), the select register holds 0, the index holds 0, every `dev_en` bit is 0, every base address and interrupt number is 0, and `pin_sel` equals the `PIN_RST` parameter.
- R2: From the locked state, two consecutive index-port writes of `UNLOCK_KEY` (default 0x5A) set `cfg_open` in the cycle after the second write. A single such write leaves the port locked. Data-port accesses between the two writes do not break the sequence.
- R3: While locked, an index-port write of any value other than `UNLOCK_KEY` cancels a half-finished sequence. Two further key writes are then needed.
- R4: While open, one index-port write of `LOCK_KEY` (default 0xA5) clears `cfg_open`. Any other index-port write while open, including `UNLOCK_KEY`, only loads the index.
- R5: While locked, every read of either port returns 0xFF, and data-port writes change no register.
- R6: An access takes two steps: an index-port write of a register number, then a data-port access. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. When open, a read of the index port returns the current index.
- R7: Register 0x10 is the device select. Registers 0x20 to 0x23 reach the bank of the selected device. Selecting a number at or above `NDEV` makes these registers read 0x00 and ignore writes.
- R8: Register 0x20 is the enable flag. A data write sets `dev_en` of the selected device to bit 0 of the byte, so 0x01 enables and 0x00 disables. The register reads back as 0x00 or 0x01.
- R9: Registers 0x21 and 0x22 hold the high and low bytes of the selected device's base address, shown on `dev_base`. Register 0x23 holds its interrupt number, shown on `dev_irq`. Each register reads back what was written.
- R10: Registers 0x11 and 0x12 read as the `CHIP_HI` and `CHIP_LO` parameters whatever device is selected, and writes to them are ignored. Register 0x13 is the read/write output pin select, shown on `pin_sel`. Unused register numbers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cfg_open | output | 1 | High while the configuration space is unlocked |
| dev_en | output | NDEV | Enable flag per logical device |
| dev_base | output | 16*NDEV | Base address per device, device i at bits [16i+15:16i] |
| dev_irq | output | 8*NDEV | Interrupt number per device, device i at bits [8i+7:8i] |
| pin_sel | output | 8 | Output pin select register |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that reset is held low at time zero, so that the unlock tracker starts from a known state. The bench drives every access from one task that raises exactly one strobe for a single cycle. It holds reset through the first edges, so both assumptions are met for the whole run. The checks on the key sequence read the tracker's armed flag. That flag changes only on index-port writes, and the stimulus places key writes, other index writes and data accesses in various orders around it.

// File: rtl/cfgp_pkg.sv
// Shared register numbers for the index/data configuration port.
// Assumes 8-bit register numbers; values are fixed by the block's decode.
package cfgp_pkg;
    localparam logic [7:0] REG_SEL     = 8'h10;
    localparam logic [7:0] REG_CHIP_HI = 8'h11;
    localparam logic [7:0] REG_CHIP_LO = 8'h12;
    localparam logic [7:0] REG_PIN     = 8'h13;
    localparam logic [7:0] REG_DEV_EN  = 8'h20;
    localparam logic [7:0] REG_BASE_HI = 8'h21;
    localparam logic [7:0] REG_BASE_LO = 8'h22;
    localparam logic [7:0] REG_IRQ     = 8'h23;
endpackage

// File: rtl/cfgp_unlock.sv
// Tracks the key sequence written to the index port and holds the open flag.
// Assumes idx_wr is one cycle per index-port write; data-port traffic is
// not seen here and so cannot break a sequence.
module cfgp_unlock #(
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] LOCK_KEY   = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic       armed
);
    // Advance the two-step unlock sequence or close on the lock byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open  <= 1'b0;
            armed <= 1'b0;
        end else if (idx_wr) begin
            if (open) begin
                if (wdata == LOCK_KEY) begin
                    open  <= 1'b0;
                    armed <= 1'b0;
                end
            end else if (wdata == UNLOCK_KEY) begin
                open  <= armed;
                armed <= !armed;
            end else begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cfgp_dev_bank.sv
// Register bank of one logical device: enable, 16-bit base, interrupt number.
// Assumes wr_en is already qualified by open state and device selection.
module cfgp_dev_bank
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  reg_num,
    input  logic [7:0]  wdata,
    output logic        en,
    output logic [15:0] base,
    output logic [7:0]  irq,
    output logic [7:0]  rd_val
);
    // Store writes aimed at this bank's registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            base <= 16'h0000;
            irq  <= 8'h00;
        end else if (wr_en) begin
            case (reg_num)
                REG_DEV_EN:  en          <= wdata[0];
                REG_BASE_HI: base[15:8]  <= wdata;
                REG_BASE_LO: base[7:0]   <= wdata;
                REG_IRQ:     irq         <= wdata;
                default:     ;
            endcase
        end
    end

    // Present the addressed bank register for reads.
    always_comb begin
        case (reg_num)
            REG_DEV_EN:  rd_val = {7'b0, en};
            REG_BASE_HI: rd_val = base[15:8];
            REG_BASE_LO: rd_val = base[7:0];
            REG_IRQ:     rd_val = irq;
            default:     rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgp_port.sv
// Index/data configuration port: the unlock tracker gates access to global
// registers and to NDEV per-device banks chosen through a select register.
// Assumes bus_wr and bus_rd are never asserted in the same cycle.
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int         NDEV       = 2,
    parameter logic [7:0] CHIP_HI    = 8'hC3,
    parameter logic [7:0] CHIP_LO    = 8'h71,
    parameter logic [7:0] PIN_RST    = 8'h00,
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] LOCK_KEY   = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_sel,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 cfg_open,
    output logic [NDEV-1:0]      dev_en,
    output logic [16*NDEV-1:0]   dev_base,
    output logic [8*NDEV-1:0]    dev_irq,
    output logic [7:0]           pin_sel
);
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    logic       armed;
    logic [7:0] idx_q;
    logic [7:0] sel_q;
    logic [7:0] bank_rd [NDEV];
    logic [7:0] dev_val;
    logic [7:0] rd_val;
    logic       idx_wr;
    logic       dat_wr;

    assign idx_wr = bus_wr && !bus_sel;
    assign dat_wr = bus_wr && bus_sel && cfg_open;

    cfgp_unlock #(.UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_wr(idx_wr),
        .wdata (bus_wdata),
        .open  (cfg_open),
        .armed (armed)
    );

    // Load the index while open, except for the lock byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr && cfg_open && bus_wdata != LOCK_KEY) begin
            idx_q <= bus_wdata;
        end
    end

    // Update the global writable registers through the data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 8'h00;
            pin_sel <= PIN_RST;
        end else if (dat_wr) begin
            if (idx_q == REG_SEL) sel_q   <= bus_wdata;
            if (idx_q == REG_PIN) pin_sel <= bus_wdata;
        end
    end

    for (genvar i = 0; i < NDEV; i++) begin : g_bank
        cfgp_dev_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (dat_wr && sel_q == 8'(i)),
            .reg_num(idx_q),
            .wdata  (bus_wdata),
            .en     (dev_en[i]),
            .base   (dev_base[16*i +: 16]),
            .irq    (dev_irq[8*i +: 8]),
            .rd_val (bank_rd[i])
        );
    end

    // Pick the read value of the selected device bank.
    always_comb begin
        dev_val = 8'h00;
        for (int i = 0; i < NDEV; i++) begin
            if (sel_q == 8'(i)) dev_val = bank_rd[i];
        end
        if (sel_q >= NDEV_B) dev_val = 8'h00;
    end

    // Form the read value from lock state, port and register number.
    always_comb begin
        if (!cfg_open) begin
            rd_val = 8'hFF;
        end else if (!bus_sel) begin
            rd_val = idx_q;
        end else begin
            case (idx_q)
                REG_SEL:     rd_val = sel_q;
                REG_CHIP_HI: rd_val = CHIP_HI;
                REG_CHIP_LO: rd_val = CHIP_LO;
                REG_PIN:     rd_val = pin_sel;
                default:     rd_val = dev_val;
            endcase
        end
    end

    // Capture read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'hFF;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/cfgp_checker.sv
// Temporal checks on the configuration port, bound into every instance.
// Assumes single-strobe accesses and reset low at time zero.
module cfgp_checker #(
    parameter int         NDEV       = 2,
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] LOCK_KEY   = 8'hA5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               bus_sel,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               cfg_open,
    input logic               armed,
    input logic [NDEV-1:0]    dev_en,
    input logic [16*NDEV-1:0] dev_base,
    input logic [8*NDEV-1:0]  dev_irq,
    input logic [7:0]         pin_sel
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!cfg_open && dev_en == '0));

    // R2
    single_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && !cfg_open && !armed && bus_wdata == UNLOCK_KEY)
        |=> (!cfg_open && armed));

    // R2
    second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && !cfg_open && armed && bus_wdata == UNLOCK_KEY)
        |=> cfg_open);

    // R3
    seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && !cfg_open && bus_wdata != UNLOCK_KEY)
        |=> (!cfg_open && !armed));

    // R4
    lock_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && cfg_open && bus_wdata == LOCK_KEY)
        |=> !cfg_open);

    // R5
    locked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_open) |=> bus_rdata == 8'hFF);

    // R5
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && !cfg_open)
        |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq)
             && $stable(pin_sel)));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel) |=> $stable(dev_en));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind cfgp_port cfgp_checker #(
    .NDEV(NDEV), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .armed(armed), .dev_en(dev_en),
    .dev_base(dev_base), .dev_irq(dev_irq), .pin_sel(pin_sel)
);

// File: tb/cfgp_port_test.sv
`timescale 1ns/1ps
module cfgp_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [1:0]  dev_en;
    logic [31:0] dev_base;
    logic [15:0] dev_irq;
    logic [7:0]  pin_sel;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    cfgp_port uut (.*);

    always #2.5 clk = ~clk;

    // behavioural model state
    bit       m_open = 0, m_armed = 0;
    int       m_idx = 0, m_sel = 0, m_pin = 0;
    int       m_en[2] = '{0, 0};
    int       m_base[2] = '{0, 0};
    int       m_irq[2] = '{0, 0};
    bit       live = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(bit port);
        if (!m_open) return 8'hFF;
        if (!port) return m_idx;
        case (m_idx)
            8'h10: return m_sel;
            8'h11: return 8'hC3;
            8'h12: return 8'h71;
            8'h13: return m_pin;
            8'h20: return (m_sel < 2) ? m_en[m_sel] : 0;
            8'h21: return (m_sel < 2) ? (m_base[m_sel] >> 8) : 0;
            8'h22: return (m_sel < 2) ? (m_base[m_sel] & 8'hFF) : 0;
            8'h23: return (m_sel < 2) ? m_irq[m_sel] : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model_write(bit port, int d);
        if (!port) begin
            if (m_open) begin
                if (d == 8'hA5) begin m_open = 0; m_armed = 0; end
                else m_idx = d;
            end else if (d == 8'h5A) begin
                if (m_armed) begin m_open = 1; m_armed = 0; end
                else m_armed = 1;
            end else m_armed = 0;
        end else if (m_open) begin
            case (m_idx)
                8'h10: m_sel = d;
                8'h13: m_pin = d;
                8'h20: if (m_sel < 2) m_en[m_sel] = d & 1;
                8'h21: if (m_sel < 2) m_base[m_sel] = (m_base[m_sel] & 8'hFF) | (d << 8);
                8'h22: if (m_sel < 2) m_base[m_sel] = (m_base[m_sel] & 16'hFF00) | d;
                8'h23: if (m_sel < 2) m_irq[m_sel] = d;
                default: ;
            endcase
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(bit port, int d);
        bus_wr = 1; bus_sel = port; bus_wdata = 8'(d);
        @(posedge clk); #1;
        model_write(port, d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(bit port, string tag);
        int exp;
        exp = model_read(port);
        bus_rd = 1; bus_sel = port;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic reg_wr(int r, int d);
        wr(0, r); wr(1, d);
    endtask

    task automatic reg_rd(int r, string tag);
        wr(0, r); rd(1, tag);
    endtask

    // compare outputs with the model on every clock
    always @(negedge clk) begin
        if (live) begin
            check("R2 cfg_open", cfg_open, m_open);
            check("R8 dev_en", dev_en, (m_en[1] << 1) | m_en[0]);
            check("R9 dev_base", dev_base, (m_base[1] << 16) | m_base[0]);
            check("R9 dev_irq", dev_irq, (m_irq[1] << 8) | m_irq[0]);
            check("R10 pin_sel", pin_sel, m_pin);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        // R1 reset state
        check("R1 open", cfg_open, 0);
        check("R1 en", dev_en, 0);
        check("R1 base", dev_base, 0);
        check("R1 pin", pin_sel, 0);
        // R5 locked reads and writes
        rd(1, "R5 locked data read");
        rd(0, "R5 locked index read");
        // R2 single key does not open; data traffic keeps sequence
        wr(0, 8'h5A);
        check("R2 single key", cfg_open, 0);
        wr(1, 8'h01);
        rd(1, "R5 read between keys");
        wr(0, 8'h5A);
        check("R2 double key", cfg_open, 1);
        wr(0, 8'hA5);
        // R3 interrupted sequence
        wr(0, 8'h5A); wr(0, 8'h33); wr(0, 8'h5A);
        check("R3 broken seq", cfg_open, 0);
        wr(0, 8'h5A);
        check("R3 restart", cfg_open, 1);
        // R6 index read back
        rd(0, "R6 index reset value");
        wr(0, 8'h5A);
        check("R4 key while open", cfg_open, 1);
        rd(0, "R4 key loads index");
        // R1 select reset and R10 globals
        reg_rd(8'h10, "R1 sel reset");
        reg_rd(8'h11, "R10 chip hi");
        reg_rd(8'h12, "R10 chip lo");
        reg_wr(8'h11, 8'h00);
        reg_rd(8'h11, "R10 chip hi write ignored");
        reg_wr(8'h13, 8'h3C);
        reg_rd(8'h13, "R10 pin sel");
        reg_rd(8'h30, "R10 unused reg");
        // R7 R8 R9 device 0
        reg_wr(8'h20, 8'h01);
        reg_wr(8'h21, 8'h12);
        reg_wr(8'h22, 8'h34);
        reg_wr(8'h23, 8'h05);
        reg_rd(8'h20, "R8 en dev0");
        reg_rd(8'h21, "R9 base hi dev0");
        // device 1
        reg_wr(8'h10, 8'h01);
        reg_rd(8'h20, "R7 dev1 en independent");
        reg_wr(8'h20, 8'hFF);
        reg_wr(8'h21, 8'hAB);
        reg_wr(8'h22, 8'hCD);
        reg_wr(8'h23, 8'h0A);
        reg_rd(8'h22, "R9 base lo dev1");
        reg_rd(8'h23, "R9 irq dev1");
        reg_rd(8'h11, "R10 chip hi with sel 1");
        // back to device 0, disable it
        reg_wr(8'h10, 8'h00);
        reg_rd(8'h22, "R7 dev0 base lo");
        reg_wr(8'h20, 8'h00);
        reg_rd(8'h20, "R8 disable dev0");
        // out of range select
        reg_wr(8'h10, 8'h03);
        reg_wr(8'h23, 8'h77);
        reg_rd(8'h23, "R7 out of range read");
        reg_rd(8'h10, "R7 select read back");
        // R4 lock
        wr(0, 8'hA5);
        check("R4 locked", cfg_open, 0);
        rd(1, "R5 data after lock");
        wr(1, 8'h99);
        rd(0, "R5 index after lock");
        // reopen and confirm registers held
        wr(0, 8'h5A); wr(0, 8'h5A);
        reg_wr(8'h10, 8'h01);
        reg_rd(8'h23, "R5 dev1 irq held");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule